// File: doc/BRIEF.md
# Variable-Length Instruction Format Decoder

This block splits an instruction word of a small embedded processor into the fields that later pipeline stages need. An instruction is either 16 bits or 32 bits long. The two lowest bits of the word give its form, and the form decides which bits hold the register indices, which bits hold the immediate, and whether a predicate and an auto-update request are present. Opcode meaning, register-file reads and the ALU are handled elsewhere. The decoder only classifies the word, routes its fields and sign-extends the immediate.

Words enter on a valid/ready stream and the decoded record leaves on a second valid/ready stream, one register stage later. The stage holds one record. `in_ready` is high when the stage is empty or when the downstream side takes the held record in the same cycle. A record that is not accepted (`out_valid` high, `out_ready` low) stays unchanged on the outputs until it is taken. Back-pressure therefore passes through to `in_ready` within the same cycle. No word is dropped and no word is duplicated.

Top module: `insn_fmt_decoder`

## Requirements
- R1: Bits 1:0 select the form. 00 gives short register (`o_fmt`=0), 10 gives short 4-bit immediate (`o_fmt`=1), 01 gives long 16-bit immediate (`o_fmt`=2) and 11 gives extended (`o_fmt`=3). `o_wide` is 1 exactly for the long and extended forms.
- R2: `o_opcode` carries word bits 7:2 in every form. `o_illegal` is 1 exactly when that field is all ones (reserved code 3Fh, that is byte FCh), in any form.
- R3: Short register form: `o_rs_a` = `o_rd` = bits 11:8, `o_rs_b` = bits 15:12, `o_use_imm` = 0 and `o_imm` = 0.
- R4: Short immediate form: `o_rs_a` = `o_rd` = bits 11:8, `o_rs_b` = 0, `o_use_imm` = 1, and `o_imm` is bits 15:12 sign-extended (range -8..7).
- R5: Long form: `o_rs_a` = bits 15:12, `o_rd` = bits 11:8, `o_rs_b` = 0, `o_use_imm` = 1, and `o_imm` is bits 31:16 sign-extended (range -32768..32767).
- R6: Extended form: `o_rs_a` = bits 11:8 and `o_rd` = bits 23:20. When bit 16 is 0, `o_rs_b` = bits 15:12, `o_use_imm` = 0 and `o_imm` = 0. When bit 16 is 1, `o_rs_b` = 0, `o_use_imm` = 1 and `o_imm` is bits 15:12 sign-extended.
- R7: Extended form: `o_pred_en` = 1, `o_cc` = bits 19:17 and `o_cr` = bits 27:24. The update mode in bits 29:28 decodes as follows: 00 means no update, 01 and 11 mean post-increment, and 10 means pre-decrement. `o_upd_en` is 1 for any nonzero mode and `o_upd_dec` is 1 only for mode 10. Bits 31:30 are ignored.
- R8: Short and long forms: `o_pred_en`, `o_cc`, `o_cr`, `o_upd_en` and `o_upd_dec` are all 0. In the short forms, bits 31:16 have no effect on any output.
- R9: `in_ready` = !`out_valid` || `out_ready`. A word accepted in cycle n is presented with `out_valid`=1 from cycle n+1. While `out_valid`=1 and `out_ready`=0, every output holds its value.
- R10: While `rst_n` is low, and in the first cycle after reset, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Decoder can take a word this cycle |
| in_word | input | 32 | Instruction word (upper half unused by short forms) |
| out_valid | output | 1 | Decoded record present |
| out_ready | input | 1 | Downstream takes the record |
| o_fmt | output | 2 | Form class (0 short reg, 1 short imm, 2 long, 3 extended) |
| o_wide | output | 1 | Instruction is 32 bits long |
| o_opcode | output | 6 | Opcode field |
| o_illegal | output | 1 | Reserved opcode seen |
| o_rs_a | output | 4 | First operand register |
| o_rs_b | output | 4 | Second operand register (0 when immediate) |
| o_rd | output | 4 | Destination register, written last |
| o_use_imm | output | 1 | Second operand is the immediate |
| o_imm | output | XLEN (32) | Sign-extended immediate |
| o_pred_en | output | 1 | Execution is predicated |
| o_cc | output | 3 | Predicate condition code |
| o_cr | output | 4 | Predicate condition-source register |
| o_upd_en | output | 1 | Auto-update of the source/destination register requested |
| o_upd_dec | output | 1 | Auto-update is pre-decrement (else post-increment) |

## Verification
The assertions check several rules on every cycle. They check the handshake rule and the hold-under-stall rule. They check that the illegal flag agrees with the opcode output and that the width flag agrees with the form class. They check that a short or long record never carries predicate or update fields, that a short immediate stays within -8..7, and that pre-decrement only appears on extended records. The exact bit positions each field is taken from cannot be shown by a property, and neither can ignoring the upper half in short forms, the four update modes, or the delivery of every accepted word in order under random stalls. These are shown by the bench, which holds a queue of accepted words and recomputes every expected field from each word.

// File: rtl/ifd_pkg.sv
package ifd_pkg;

  localparam int INSN_W = 32;
  localparam int HALF_W = 16;
  localparam int OPC_W  = 6;
  localparam int REG_W  = 4;
  localparam int CC_W   = 3;
  localparam int UPD_W  = 2;

  // Bit positions inside the instruction word
  localparam int OPC_LSB   = 2;
  localparam int SD_LSB    = 8;
  localparam int SI_LSB    = 12;
  localparam int HI_LSB    = 16;
  localparam int XSEL_BIT  = 16;
  localparam int CC_LSB    = 17;
  localparam int D3_LSB    = 20;
  localparam int CR_LSB    = 24;
  localparam int UPD_LSB   = 28;

  localparam logic [OPC_W-1:0] OPC_RESERVED = '1;
  localparam logic [UPD_W-1:0] UPD_PREDEC   = 2'b10;

  typedef enum logic [1:0] {
    FMT_SREG = 2'd0,
    FMT_SIMM = 2'd1,
    FMT_LONG = 2'd2,
    FMT_EXT  = 2'd3
  } fmt_e;

  // Raw slices of the word, before any form-dependent routing
  typedef struct packed {
    logic [1:0]       form_bits;
    logic [OPC_W-1:0] opc;
    logic [REG_W-1:0] sd;
    logic [REG_W-1:0] si;
    logic [REG_W-1:0] d3;
    logic [REG_W-1:0] cr;
    logic [CC_W-1:0]  cc;
    logic             xsel;
    logic [UPD_W-1:0] upd;
  } raw_t;

  // Routed record without the immediate
  typedef struct packed {
    fmt_e             fmt;
    logic             wide;
    logic [OPC_W-1:0] opc;
    logic             illegal;
    logic [REG_W-1:0] rs_a;
    logic [REG_W-1:0] rs_b;
    logic [REG_W-1:0] rd;
    logic             use_imm;
    logic             pred_en;
    logic [CC_W-1:0]  cc;
    logic [REG_W-1:0] cr;
    logic             upd_en;
    logic             upd_dec;
  } dec_t;

endpackage

// File: rtl/ifd_fields.sv
module ifd_fields
  import ifd_pkg::*;
(
  input  logic [INSN_W-1:0] word,
  output raw_t              raw,
  output logic [HALF_W-1:0] hi
);

  always_comb begin
    raw.form_bits = word[1:0];
    raw.opc       = word[OPC_LSB +: OPC_W];
    raw.sd        = word[SD_LSB  +: REG_W];
    raw.si        = word[SI_LSB  +: REG_W];
    raw.xsel      = word[XSEL_BIT];
    raw.cc        = word[CC_LSB  +: CC_W];
    raw.d3        = word[D3_LSB  +: REG_W];
    raw.cr        = word[CR_LSB  +: REG_W];
    raw.upd       = word[UPD_LSB +: UPD_W];
    hi            = word[HI_LSB  +: HALF_W];
  end

endmodule

// File: rtl/ifd_route.sv
module ifd_route
  import ifd_pkg::*;
(
  input  raw_t raw,
  output dec_t dec
);

  always_comb begin
    dec         = '0;
    dec.opc     = raw.opc;
    dec.illegal = (raw.opc == OPC_RESERVED);
    dec.wide    = raw.form_bits[0];
    unique case (raw.form_bits)
      2'b00:   dec.fmt = FMT_SREG;
      2'b10:   dec.fmt = FMT_SIMM;
      2'b01:   dec.fmt = FMT_LONG;
      default: dec.fmt = FMT_EXT;
    endcase

    unique case (dec.fmt)
      FMT_SREG: begin
        dec.rs_a = raw.sd;
        dec.rs_b = raw.si;
        dec.rd   = raw.sd;
      end
      FMT_SIMM: begin
        dec.rs_a    = raw.sd;
        dec.rd      = raw.sd;
        dec.use_imm = 1'b1;
      end
      FMT_LONG: begin
        dec.rs_a    = raw.si;
        dec.rd      = raw.sd;
        dec.use_imm = 1'b1;
      end
      default: begin
        dec.rs_a    = raw.sd;
        dec.rd      = raw.d3;
        dec.use_imm = raw.xsel;
        dec.rs_b    = raw.xsel ? '0 : raw.si;
        dec.pred_en = 1'b1;
        dec.cc      = raw.cc;
        dec.cr      = raw.cr;
        dec.upd_en  = |raw.upd;
        dec.upd_dec = (raw.upd == UPD_PREDEC);
      end
    endcase
  end

endmodule

// File: rtl/ifd_immgen.sv
module ifd_immgen
  import ifd_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  fmt_e              fmt,
  input  logic              xsel,
  input  logic [REG_W-1:0]  si,
  input  logic [HALF_W-1:0] hi,
  output logic [XLEN-1:0]   imm
);

  localparam int PAD4  = XLEN - REG_W;
  localparam int PAD16 = XLEN - HALF_W;

  logic [XLEN-1:0] imm4_x;
  logic [XLEN-1:0] imm16_x;

  generate
    if (PAD16 > 0) begin : g_pad
      assign imm16_x = {{PAD16{hi[HALF_W-1]}}, hi};
    end else begin : g_nopad
      assign imm16_x = hi[XLEN-1:0];
    end
  endgenerate

  assign imm4_x = {{PAD4{si[REG_W-1]}}, si};

  always_comb begin
    unique case (fmt)
      FMT_SIMM: imm = imm4_x;
      FMT_LONG: imm = imm16_x;
      FMT_EXT:  imm = xsel ? imm4_x : '0;
      default:  imm = '0;
    endcase
  end

endmodule

// File: rtl/ifd_stage.sv
module ifd_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

endmodule

// File: rtl/insn_fmt_decoder.sv
module insn_fmt_decoder
  import ifd_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [INSN_W-1:0] in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        o_fmt,
  output logic              o_wide,
  output logic [OPC_W-1:0]  o_opcode,
  output logic              o_illegal,
  output logic [REG_W-1:0]  o_rs_a,
  output logic [REG_W-1:0]  o_rs_b,
  output logic [REG_W-1:0]  o_rd,
  output logic              o_use_imm,
  output logic [XLEN-1:0]   o_imm,
  output logic              o_pred_en,
  output logic [CC_W-1:0]   o_cc,
  output logic [REG_W-1:0]  o_cr,
  output logic              o_upd_en,
  output logic              o_upd_dec
);

  localparam int DEC_W = $bits(dec_t);
  localparam int PAY_W = DEC_W + XLEN;

  raw_t              raw;
  logic [HALF_W-1:0] hi;
  dec_t              dec_d;
  logic [XLEN-1:0]   imm_d;
  logic [PAY_W-1:0]  pay_q;
  dec_t              dec_q;
  logic [XLEN-1:0]   imm_q;

  ifd_fields u_fields (
    .word (in_word),
    .raw  (raw),
    .hi   (hi)
  );

  ifd_route u_route (
    .raw (raw),
    .dec (dec_d)
  );

  ifd_immgen #(.XLEN(XLEN)) u_imm (
    .fmt  (dec_d.fmt),
    .xsel (raw.xsel),
    .si   (raw.si),
    .hi   (hi),
    .imm  (imm_d)
  );

  ifd_stage #(.W(PAY_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   ({dec_d, imm_d}),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (pay_q)
  );

  assign {dec_q, imm_q} = pay_q;

  assign o_fmt     = dec_q.fmt;
  assign o_wide    = dec_q.wide;
  assign o_opcode  = dec_q.opc;
  assign o_illegal = dec_q.illegal;
  assign o_rs_a    = dec_q.rs_a;
  assign o_rs_b    = dec_q.rs_b;
  assign o_rd      = dec_q.rd;
  assign o_use_imm = dec_q.use_imm;
  assign o_imm     = imm_q;
  assign o_pred_en = dec_q.pred_en;
  assign o_cc      = dec_q.cc;
  assign o_cr      = dec_q.cr;
  assign o_upd_en  = dec_q.upd_en;
  assign o_upd_dec = dec_q.upd_dec;

endmodule

// File: rtl/ifd_checker.sv
module ifd_checker
  import ifd_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [1:0]        o_fmt,
  input logic              o_wide,
  input logic [OPC_W-1:0]  o_opcode,
  input logic              o_illegal,
  input logic [REG_W-1:0]  o_rs_a,
  input logic [REG_W-1:0]  o_rd,
  input logic              o_use_imm,
  input logic [XLEN-1:0]   o_imm,
  input logic              o_pred_en,
  input logic              o_upd_en,
  input logic              o_upd_dec
);

  a_r10_idle_in_reset: assert property (@(posedge clk)
    !rst_n |-> !out_valid);

  a_r9_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(o_fmt) && $stable(o_opcode)
      && $stable(o_rd) && $stable(o_rs_a) && $stable(o_imm) && $stable(o_use_imm)));

  a_r2_illegal_flag: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (o_illegal == (o_opcode == OPC_RESERVED)));

  a_r1_wide_class: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (o_wide == (o_fmt == FMT_LONG || o_fmt == FMT_EXT)));

  a_r8_no_ext_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && o_fmt != FMT_EXT) |-> (!o_pred_en && !o_upd_en && !o_upd_dec));

  a_r3_short_two_operand: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !o_wide) |-> (o_rs_a == o_rd));

  a_r3_reg_no_imm: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && o_fmt == FMT_SREG) |-> (!o_use_imm && o_imm == '0));

  a_r4_imm4_range: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && o_fmt == FMT_SIMM) |->
      (o_use_imm && ($countones(o_imm[XLEN-1:3]) == 0 || (&o_imm[XLEN-1:3]))));

  a_r7_predec_ext_only: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && o_upd_dec) |-> (o_upd_en && o_fmt == FMT_EXT));

endmodule

bind insn_fmt_decoder ifd_checker #(.XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .o_fmt     (o_fmt),
  .o_wide    (o_wide),
  .o_opcode  (o_opcode),
  .o_illegal (o_illegal),
  .o_rs_a    (o_rs_a),
  .o_rd      (o_rd),
  .o_use_imm (o_use_imm),
  .o_imm     (o_imm),
  .o_pred_en (o_pred_en),
  .o_upd_en  (o_upd_en),
  .o_upd_dec (o_upd_dec)
);

// File: tb/test_insn_fmt_decoder.sv
module test_insn_fmt_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [1:0]  o_fmt;
  logic        o_wide;
  logic [5:0]  o_opcode;
  logic        o_illegal;
  logic [3:0]  o_rs_a, o_rs_b, o_rd, o_cr;
  logic        o_use_imm, o_pred_en, o_upd_en, o_upd_dec;
  logic [31:0] o_imm;
  logic [2:0]  o_cc;

  int nchk = 0;
  int nerr = 0;
  logic [31:0] q[$];
  logic [31:0] lfsr = 32'h1D2C_3B4A;

  always #2.5 clk = ~clk;

  insn_fmt_decoder i_insn_fmt_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
    .o_fmt(o_fmt), .o_wide(o_wide), .o_opcode(o_opcode), .o_illegal(o_illegal),
    .o_rs_a(o_rs_a), .o_rs_b(o_rs_b), .o_rd(o_rd), .o_use_imm(o_use_imm),
    .o_imm(o_imm), .o_pred_en(o_pred_en), .o_cc(o_cc), .o_cr(o_cr),
    .o_upd_en(o_upd_en), .o_upd_dec(o_upd_dec)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] next_rand();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return lfsr;
  endfunction

  // Reference: recompute every output from the accepted word
  task automatic compare(input logic [31:0] w);
    int fmt;
    logic [3:0] ra, rb, rd, cr;
    logic use_imm, pe, ue, ud;
    logic [31:0] imm;
    logic [2:0] cc;
    logic [1:0] upd;
    string otag, xtag;
    case (w[1:0])
      2'b00: fmt = 0;
      2'b10: fmt = 1;
      2'b01: fmt = 2;
      default: fmt = 3;
    endcase
    ra = w[11:8]; rb = 4'd0; rd = w[11:8]; use_imm = 1'b0; imm = 32'd0;
    pe = 1'b0; cc = 3'd0; cr = 4'd0; ue = 1'b0; ud = 1'b0;
    if (fmt == 0) begin
      otag = "R3"; rb = w[15:12];
    end else if (fmt == 1) begin
      otag = "R4"; use_imm = 1'b1; imm = 32'($signed(w[15:12]));
    end else if (fmt == 2) begin
      otag = "R5"; ra = w[15:12]; use_imm = 1'b1; imm = 32'($signed(w[31:16]));
    end else begin
      otag = "R6"; rd = w[23:20];
      if (w[16]) begin use_imm = 1'b1; imm = 32'($signed(w[15:12])); end
      else rb = w[15:12];
      pe = 1'b1; cc = w[19:17]; cr = w[27:24]; upd = w[29:28];
      ue = (upd != 2'b00); ud = (upd == 2'b10);
    end
    xtag = (fmt == 3) ? "R7" : "R8";
    check({o_fmt, o_wide, o_opcode, o_illegal} ==
          {2'(fmt), (fmt >= 2), w[7:2], (w[7:2] == 6'h3F)},
          "R1 R2", "fmt/wide/opcode/illegal",
          64'({o_fmt, o_wide, o_opcode, o_illegal}),
          64'({2'(fmt), (fmt >= 2), w[7:2], (w[7:2] == 6'h3F)}));
    check({o_rs_a, o_rs_b, o_rd, o_use_imm, o_imm} == {ra, rb, rd, use_imm, imm},
          otag, "rs_a/rs_b/rd/use_imm/imm",
          64'({o_rs_a, o_rs_b, o_rd, o_use_imm, o_imm}),
          64'({ra, rb, rd, use_imm, imm}));
    check({o_pred_en, o_cc, o_cr, o_upd_en, o_upd_dec} == {pe, cc, cr, ue, ud},
          xtag, "pred/cc/cr/upd",
          64'({o_pred_en, o_cc, o_cr, o_upd_en, o_upd_dec}),
          64'({pe, cc, cr, ue, ud}));
  endtask

  task automatic step(input logic [31:0] w, input logic v, input logic r);
    logic exp_rdy;
    @(negedge clk);
    check(out_valid == (q.size() != 0), "R9", "out_valid",
          64'(out_valid), 64'(q.size() != 0));
    if (out_valid && q.size() != 0) compare(q[0]);
    in_word = w; in_valid = v; out_ready = r;
    #1;
    exp_rdy = (q.size() == 0) || r;
    check(in_ready == exp_rdy, "R9", "in_ready", 64'(in_ready), 64'(exp_rdy));
    if (q.size() != 0 && r) void'(q.pop_front());
    if (v && exp_rdy) q.push_back(w);
  endtask

  initial begin
    logic [31:0] dir[15];
    dir = '{32'h0000_00FC, 32'hABCD_5214, 32'h1234_8216, 32'hFFFF_7216,
            32'h8000_3115, 32'h7FFF_3115, 32'h1234_5217, 32'h0031_F217,
            32'h0010_0017, 32'h1000_0017, 32'h2000_0017, 32'h3000_0017,
            32'hC000_0017, 32'h00F0_00FF, 32'h0000_A0FE};
    // R10: reset holds the output empty
    repeat (3) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R10", "out_valid in reset", 64'(out_valid), 64'd0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    step(32'd0, 1'b0, 1'b1);
    // Directed words, some under stall
    foreach (dir[i]) begin
      step(dir[i], 1'b1, (i % 4) != 3);
      if (i % 5 == 2) step(32'd0, 1'b0, 1'b0);
    end
    // R9: fill then stall with input still offered
    step(32'h5555_1234, 1'b1, 1'b0);
    step(32'h6666_4321, 1'b1, 1'b0);
    step(32'h6666_4321, 1'b1, 1'b0);
    step(32'h6666_4321, 1'b1, 1'b1);
    // Random words with random back-pressure
    for (int n = 0; n < 600; n++) begin
      logic [31:0] w;
      logic [31:0] c;
      w = next_rand();
      c = next_rand();
      step(w, c[3] | c[9], c[5] | c[12]);
    end
    // Drain
    repeat (4) step(32'd0, 1'b0, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule